// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block is the receive front end of a target on a two-wire serial bus. It oversamples the clock line (SCL) and the data line (SDA) with the system clock. From those samples it detects start and stop conditions and shifts in the first byte after each start. It compares the seven address bits of that byte with a fixed device-type code joined to three strap-pin bits.

On a match it pulls SDA low for the acknowledge bit. The pull-down goes through an output-enable that drives an open-drain pad. The all-zero general-call address is also accepted, but only for writes. After a write address is acknowledged, every further byte goes out on a valid/ready stream.

The stream follows these rules for back-pressure:
- A byte is offered with `rx_valid`. It stays put, with `rx_data` and `rx_gcall` unchanged, until a cycle in which `rx_ready` is high.
- The receive slot is a single entry. If a byte finishes while the slot still holds an unaccepted byte, the new byte is not acknowledged and is discarded. The bus master sees the refusal as a not-acknowledge.
- A cycle with `rx_ready` high frees the slot in time for a byte finishing in that same cycle.

Top module: `i2c_addr_listener`

## Requirements
- R1: A start condition (SDA falling while SCL is high) opens an address phase. A stop condition (SDA rising while SCL is high) ends the transaction. Bytes clocked after a stop and before the next start are never acknowledged.
- R2: A start seen at any point, including partway through a byte or after a refused address, clears the bit count and begins a fresh address phase (repeated start).
- R3: The first byte after a start is taken MSB first. Its upper seven bits are the address and its least significant bit is the direction: 0 for write, 1 for read.
- R4: An address equal to {TYPE_CODE, strap_i} is acknowledged in both directions. TYPE_CODE is 4'b1010 by default and forms address bits 6..3; strap_i forms bits 2..0.
- R5: After an address that is neither a match nor a general-call write, SDA is not driven for the rest of that transaction, data bytes included.
- R6: Address 0 with direction write is acknowledged, and the following bytes are received with `rx_gcall` = 1. Address 0 with direction read is not acknowledged.
- R7: `sda_oe` = 1 pulls SDA low. It rises after the SCL falling edge that ends the eighth bit of an acknowledged byte, and drops after the next SCL falling edge. It is 0 at every other time.
- R8: After a matching read address is acknowledged, SDA is never driven again in that transaction.
- R9: Each byte written after an acknowledged write address is presented MSB-first on `rx_data` with `rx_valid` = 1, acknowledged, and held unchanged until `rx_ready` is sampled high.
- R10: A data byte that completes while the slot holds an unaccepted byte is not acknowledged. The slot keeps the older byte.
- R11: During and after reset, `sda_oe` = 0 and `rx_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | STRAP_W | Pin-strapped low address bits |
| sda_oe | output | 1 | 1 enables the open-drain pull-down on SDA |
| rx_data | output | TYPE_W+STRAP_W+1 | Received write byte |
| rx_valid | output | 1 | rx_data holds a byte not yet accepted |
| rx_ready | input | 1 | Consumer accepts the offered byte this cycle |
| rx_gcall | output | 1 | Offered byte belongs to a general-call transaction |

## Verification
The bench builds the block with its defaults: a four-bit type code of 1010, three strap bits, general call enabled and a two-flop synchronizer. With seven address bits it can send every one of the 256 possible first bytes under one strap setting. Under each of the other seven strap settings it sends the sixteen first bytes of the 1010 type family. Every case has its acknowledge predicted from arithmetic on the address. The small single-entry slot lets it drive a stalled consumer into a refused byte and then recover.

// File: rtl/i2c_listen_pkg.sv
package i2c_listen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_IGNORE
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // Lines idle high, so reset to one to avoid a false edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);
  // Any SDA movement while SCL is high is a bus condition.
  assign start_o = scl_lvl & sda_fall;
  assign stop_o  = scl_lvl & sda_rise;
endmodule

// File: rtl/i2c_frame_engine.sv
module i2c_frame_engine
  import i2c_listen_pkg::*;
#(
  parameter int                TYPE_W    = 4,
  parameter int                STRAP_W   = 3,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010,
  parameter bit                GCALL_EN  = 1'b1,
  localparam int               BYTE_W    = TYPE_W + STRAP_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_lvl,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               drive_o,
  output logic [BYTE_W-1:0]  data_o,
  output logic               valid_o,
  input  logic               ready_i,
  output logic               gcall_o
);
  localparam int ADDR_W = TYPE_W + STRAP_W;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_W + 1);

  phase_e              phase, nxt;
  logic [CNT_W-1:0]    cnt;
  logic [BYTE_W-1:0]   shreg;
  logic                gcall_txn;

  logic [ADDR_W-1:0]   own_addr;
  logic                rw_bit, is_match, is_gcall, addr_ack, slot_free;
  phase_e              addr_next;

  always_comb begin
    own_addr  = {TYPE_CODE, strap_i};
    rw_bit    = shreg[0];
    is_match  = (shreg[BYTE_W-1:1] == own_addr);
    is_gcall  = GCALL_EN && (shreg[BYTE_W-1:1] == '0) && !rw_bit;
    addr_ack  = is_match || is_gcall;
    addr_next = ((is_match && !rw_bit) || is_gcall) ? PH_DATA : PH_IGNORE;
    slot_free = !valid_o || ready_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      nxt       <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      drive_o   <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      gcall_o   <= 1'b0;
      gcall_txn <= 1'b0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (start_evt) begin
        phase   <= PH_ADDR;
        cnt     <= '0;
        drive_o <= 1'b0;
      end else if (stop_evt) begin
        phase   <= PH_IDLE;
        cnt     <= '0;
        drive_o <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && cnt < LAST_CNT) begin
          shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          cnt   <= cnt + 1'b1;
        end else if (scl_fall && cnt == LAST_CNT) begin
          cnt <= ACK_CNT;
          case (phase)
            PH_ADDR: begin
              drive_o   <= addr_ack;
              nxt       <= addr_next;
              gcall_txn <= is_gcall;
            end
            PH_DATA: begin
              if (slot_free) begin
                drive_o <= 1'b1;
                data_o  <= shreg;
                valid_o <= 1'b1;
                gcall_o <= gcall_txn;
              end
            end
            default: ;
          endcase
        end else if (scl_fall && cnt == ACK_CNT) begin
          cnt     <= '0;
          drive_o <= 1'b0;
          if (phase == PH_ADDR) phase <= nxt;
        end
      end
    end
  end

  // R7
  oe_in_ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> (cnt == ACK_CNT));

  // R5 R8
  ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !drive_o);

  // R9
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(gcall_o)));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_ADDR && cnt == '0 && !drive_o));

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (phase == PH_IDLE && !drive_o));

  // R10
  full_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && scl_fall && cnt == LAST_CNT && valid_o && !ready_i
     && !start_evt && !stop_evt) |=> !drive_o);
endmodule

// File: rtl/i2c_addr_listener.sv
module i2c_addr_listener #(
  parameter int                TYPE_W      = 4,
  parameter int                STRAP_W     = 3,
  parameter logic [TYPE_W-1:0] TYPE_CODE   = 4'b1010,
  parameter bit                GCALL_EN    = 1'b1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  input  logic [STRAP_W-1:0]          strap_i,
  output logic                        sda_oe,
  output logic [TYPE_W+STRAP_W:0]     rx_data,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic                        rx_gcall
);
  localparam int NLINES = 2;
  localparam int L_SCL  = 0;
  localparam int L_SDA  = 1;

  logic [NLINES-1:0] line_in, lvl, rise, fall;
  logic              start_evt, stop_evt;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(line_in[g]),
      .lvl_o (lvl[g]),
      .rise_o(rise[g]),
      .fall_o(fall[g])
    );
  end

  i2c_cond_detect u_cond (
    .scl_lvl (lvl[L_SCL]),
    .sda_rise(rise[L_SDA]),
    .sda_fall(fall[L_SDA]),
    .start_o (start_evt),
    .stop_o  (stop_evt)
  );

  i2c_frame_engine #(
    .TYPE_W   (TYPE_W),
    .STRAP_W  (STRAP_W),
    .TYPE_CODE(TYPE_CODE),
    .GCALL_EN (GCALL_EN)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (rise[L_SCL]),
    .scl_fall (fall[L_SCL]),
    .sda_lvl  (lvl[L_SDA]),
    .strap_i  (strap_i),
    .drive_o  (sda_oe),
    .data_o   (rx_data),
    .valid_o  (rx_valid),
    .ready_i  (rx_ready),
    .gcall_o  (rx_gcall)
  );
endmodule

// File: tb/i2c_addr_listener_tb.sv
module i2c_addr_listener_tb;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       rx_ready = 1'b0;
  logic       sda_oe, rx_valid, rx_gcall;
  logic [7:0] rx_data;
  logic       sda_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_addr_listener u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe(sda_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_gcall(rx_gcall)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b, output logic smp, output logic oe);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    smp = sda_bus; oe = sda_oe;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // Returns ack seen on the bus, stray drive during data bits, release after ack.
  task automatic send_byte(input logic [7:0] b, output logic ack,
                           output logic stray, output logic held);
    logic s, o;
    stray = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], s, o);
      stray |= o;
    end
    send_bit(1'b1, s, o);
    ack  = !s;
    held = sda_oe;
  endtask

  task automatic pop();
    rx_ready = 1'b1; tick(1);
    rx_ready = 1'b0; tick(1);
  endtask

  task automatic expect_byte(input logic [7:0] d, input logic gc, input string req);
    chk(rx_valid == 1'b1, req, rx_valid, 1);
    chk(rx_data == d, req, rx_data, d);
    chk(rx_gcall == gc, req, rx_gcall, gc);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic ack, stray, held;
    logic [7:0] own;
    tick(5);
    // R11 reset state
    chk(sda_oe == 1'b0, "R11 oe in reset", sda_oe, 0);
    chk(rx_valid == 1'b0, "R11 valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R11 oe after reset", sda_oe, 0);
    chk(rx_valid == 1'b0, "R11 valid after reset", rx_valid, 0);

    // R3 R4 R6 sweep of first bytes
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 128; a++) begin
        for (int rw = 0; rw < 2; rw++) begin
          bit m, e;
          if (s != 5 && a[6:3] != 4'b1010) continue;
          m = (a == {4'b1010, s[2:0]});
          e = m || (a == 0 && rw == 0);
          bus_start();
          send_byte({7'(a), 1'(rw)}, ack, stray, held);
          chk(ack == e, "R4 R6 address ack", ack, e);
          chk(stray == 1'b0, "R3 no drive in address bits", stray, 0);
          chk(held == 1'b0, "R7 released after ack bit", held, 0);
          if (m && rw == 1) begin
            send_byte(8'hFF, ack, stray, held);
            chk(!ack && !stray, "R8 read silent", {ack, stray}, 0);
          end else if (!e && a[6:3] == 4'b1010) begin
            send_byte(8'h00, ack, stray, held);
            chk(!ack && !stray, "R5 mismatch silent", {ack, stray}, 0);
          end
          bus_stop();
          if (rx_valid) pop();
        end
      end
    end

    strap = 3'd5;
    own = {4'b1010, 3'd5, 1'b0};

    // R9 write data with held slot
    bus_start();
    send_byte(own, ack, stray, held);
    chk(ack, "R4 write address", ack, 1);
    foreach (own[i]) begin end
    begin
      logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
      foreach (pats[i]) begin
        send_byte(pats[i], ack, stray, held);
        chk(ack && !stray, "R9 data ack", {ack, stray}, 2'b10);
        expect_byte(pats[i], 1'b0, "R9 data out");
        tick(10);
        expect_byte(pats[i], 1'b0, "R9 held until ready");
        pop();
        chk(rx_valid == 1'b0, "R9 popped", rx_valid, 0);
      end
    end

    // R10 back-pressure
    send_byte(8'h11, ack, stray, held);
    chk(ack, "R10 first ack", ack, 1);
    send_byte(8'h22, ack, stray, held);
    chk(!ack, "R10 full refuses", ack, 0);
    expect_byte(8'h11, 1'b0, "R10 old byte kept");
    pop();
    send_byte(8'h33, ack, stray, held);
    chk(ack, "R10 ack after pop", ack, 1);
    expect_byte(8'h33, 1'b0, "R10 new byte");
    pop();
    bus_stop();

    // R1 bytes after stop are ignored
    scl_m = 1'b0; tick(Q);
    send_byte(own, ack, stray, held);
    chk(!ack && !stray, "R1 idle after stop", {ack, stray}, 0);
    send_byte(8'h5A, ack, stray, held);
    chk(!ack && rx_valid == 1'b0, "R1 no data after stop", {ack, rx_valid}, 0);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);

    // R6 general call
    bus_start();
    send_byte(8'h00, ack, stray, held);
    chk(ack, "R6 gcall write ack", ack, 1);
    send_byte(8'h5A, ack, stray, held);
    chk(ack, "R6 gcall data ack", ack, 1);
    expect_byte(8'h5A, 1'b1, "R6 gcall data");
    pop();
    bus_stop();
    bus_start();
    send_byte(8'h01, ack, stray, held);
    chk(!ack, "R6 gcall read refused", ack, 0);
    bus_stop();

    // R2 repeated start mid-byte
    bus_start();
    begin
      logic s0, o0;
      for (int i = 7; i >= 4; i--) send_bit(own[i] ^ 1'b1, s0, o0);
    end
    bus_start();
    send_byte(own, ack, stray, held);
    chk(ack, "R2 restart mid-byte", ack, 1);
    send_byte(8'h77, ack, stray, held);
    chk(ack, "R2 data after restart", ack, 1);
    expect_byte(8'h77, 1'b0, "R2 data value");
    pop();
    // R2 restart after refused address
    bus_start();
    send_byte(8'h30, ack, stray, held);
    chk(!ack, "R5 foreign address", ack, 0);
    bus_start();
    send_byte(own, ack, stray, held);
    chk(ack, "R2 restart after refusal", ack, 1);
    bus_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule